// File: doc/BRIEF.md
# Flash Command Interface and Status Register

This block is the command front end of a flash-style memory. The host writes command bytes in the low byte of `wr_data` on single-cycle `wr_en` strobes; the upper byte is ignored when a byte is taken as a command. The block decodes these writes into one-cycle and two-cycle sequences and chooses what a later read returns: the array, the status byte, the signature space or the query table. It starts program and erase work on an external program/erase engine with a one-cycle start pulse. It also forwards suspend and resume requests to that engine.

An 8-bit status byte reports progress and errors. Bit 7 is ready (1) or busy (0). Bit 6 is erase suspended. Bit 5 is erase error. Bit 4 is program error. Bit 3 is supply low. Bit 2 is program suspended. Bit 1 is protected-block attempt. Bit 0 always reads 0. The error bits hold their value until a clear-status command.

Every output is registered. The result of a write strobe sampled at a rising clock edge appears on the outputs just after that edge.

Top module: `fcmd_ctrl`

## Requirements
- R1: After synchronous reset, `status` reads 80h, `rd_mode` reads 0 and no pulse output is high.
- R2: From idle, the command bytes below select the read mode (`rd_mode` encoding 0 array, 1 status, 2 signature, 3 query):
  - FFh selects 0.
  - 70h selects 1.
  - 90h selects 2.
  - 98h selects 3.
- R3: Program sequence:
  - 40h or 10h followed by one more write pulses `eng_start` for one cycle with `eng_op`=1.
  - `eng_addr` and `eng_wdata` carry that second write's address and full data word.
  - Status bit 7 drops to 0 and `rd_mode` becomes 1.
- R4: 20h followed by D0h starts a block erase (`eng_op`=2). 80h followed by D0h starts a bank erase (`eng_op`=3).
- R5: If the byte after 20h or 80h is not D0h:
  - Status bits 5 and 4 are set.
  - No start is issued.
  - Bit 7 stays 1 and `rd_mode` becomes 1.
- R6: After 60h, the second byte selects the action:
  - 01h pulses start with `eng_op`=5.
  - D0h pulses start with `eng_op`=6.
  - 2Fh pulses start with `eng_op`=7.
  - 03h pulses start with `eng_op`=8.
  - None of these clear bit 7.
  - Any other second byte issues no start and sets `rd_mode` to 0.
  - C0h followed by a data write starts a protection-register program (`eng_op`=4), which runs like a program.
- R7: While an operation runs (bit 7 = 0), only 70h and B0h have an effect. FFh does not change `rd_mode`, and no other byte causes a start.
- R8: `eng_done` while running sets bit 7. If `eng_fail` is also high, it sets bit 5 for erase operations, or bit 4 for program and protection-register program.
- R9: B0h while running pulses `eng_suspend`, sets bit 7, and sets bit 6 (erase) or bit 2 (program).
- R10: While suspended:
  - D0h pulses `eng_resume` and clears bits 7, 6 and 2.
  - Read-mode bytes (FFh, 70h, 90h, 98h) change `rd_mode` as in R2.
- R11: If `blk_prot` is high on the write that would start a program or erase, bit 1 is set and no start is issued.
- R12: If `vpp_ok` is low on that write, bit 3 is set and no start is issued. This check takes priority over the protected check, so bit 1 is left unchanged.
- R13: 50h clears bits 1, 3, 4 and 5, leaves bits 7, 6 and 2, and sets `rd_mode` to 0. Error bits are never cleared by anything else.
- R14: An unknown byte in idle sets `rd_mode` to 0 and changes neither the status byte nor the pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per host write |
| wr_addr | input | ADDR_W | Address of the host write |
| wr_data | input | DATA_W | Data of the host write; low byte is the command |
| eng_done | input | 1 | Engine finished the running operation |
| eng_fail | input | 1 | Engine failure, valid with `eng_done` |
| blk_prot | input | 1 | The addressed block is protected |
| vpp_ok | input | 1 | Program supply is above lockout |
| eng_start | output | 1 | One-cycle engine start |
| eng_op | output | 4 | Operation code of the last start |
| eng_addr | output | ADDR_W | Address captured at start |
| eng_wdata | output | DATA_W | Data word captured at start |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| rd_mode | output | 2 | Read source select |
| status | output | 8 | Status byte |

## Verification
The bench targets the following corner cases:
- **Read-array while running.** A decoder that honours FFh during an operation would switch `rd_mode` to array and hide the busy status from the host.
- **Bad erase confirm.** A design that treated this like any other invalid sequence would lose the two error bits.
- **Low supply with a protected block at the same time.** This shows whether the supply check wins, which leaves bit 1 untouched.
- **Clear-status while suspended, with old errors pending.** A clear that touched every bit would drop the suspend flag. A design whose errors were not sticky would lose the bits before the clear.
- **Failure classification and suspend-bit choice.** These are checked for both erase and program, so swapping bits 4/5 or 6/2 is caught.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int CMD_W  = 8;
    localparam int STAT_W = 8;

    // command bytes
    localparam logic [CMD_W-1:0] C_RD_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] C_RD_STATUS = 8'h70;
    localparam logic [CMD_W-1:0] C_RD_SIGN   = 8'h90;
    localparam logic [CMD_W-1:0] C_RD_QUERY  = 8'h98;
    localparam logic [CMD_W-1:0] C_CLEAR     = 8'h50;
    localparam logic [CMD_W-1:0] C_SUSPEND   = 8'hB0;
    localparam logic [CMD_W-1:0] C_CONFIRM   = 8'hD0;
    localparam logic [CMD_W-1:0] C_PROG      = 8'h40;
    localparam logic [CMD_W-1:0] C_PROG_ALT  = 8'h10;
    localparam logic [CMD_W-1:0] C_BLK_ERASE = 8'h20;
    localparam logic [CMD_W-1:0] C_BNK_ERASE = 8'h80;
    localparam logic [CMD_W-1:0] C_SETUP_60  = 8'h60;
    localparam logic [CMD_W-1:0] C_OTP_PROG  = 8'hC0;
    localparam logic [CMD_W-1:0] C_PROTECT   = 8'h01;
    localparam logic [CMD_W-1:0] C_LOCK      = 8'h2F;
    localparam logic [CMD_W-1:0] C_CFG       = 8'h03;

    // status bit positions
    localparam int SB_READY = 7;
    localparam int SB_ESUSP = 6;
    localparam int SB_EERR  = 5;
    localparam int SB_PERR  = 4;
    localparam int SB_VLOW  = 3;
    localparam int SB_PSUSP = 2;
    localparam int SB_PROT  = 1;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_PROG       = 4'd1,
        OP_BLK_ERASE  = 4'd2,
        OP_BANK_ERASE = 4'd3,
        OP_OTP_PROG   = 4'd4,
        OP_PROTECT    = 4'd5,
        OP_UNPROTECT  = 4'd6,
        OP_LOCK       = 4'd7,
        OP_CFG        = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_SIGN   = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG_DATA,
        ST_ERASE_CONF,
        ST_SETUP60,
        ST_OTP_DATA,
        ST_BUSY,
        ST_SUSP
    } cis_e;

    // controls consumed by the top-level registers
    typedef struct packed {
        logic   start;
        op_e    start_op;
        logic   susp;
        logic   resume;
        logic   rm_we;
        rmode_e rm;
        logic   pend_we;
        op_e    pend_op;
    } ctl_t;

    // events consumed by the status register
    typedef struct packed {
        logic clear;
        logic prot;
        logic vlow;
        logic abort;
        logic busy;
        logic done;
        logic fail;
        logic susp;
        logic resume;
    } stev_t;

    function automatic logic is_erase(op_e op);
        return (op == OP_BLK_ERASE) || (op == OP_BANK_ERASE);
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  cis_e             state,
    input  op_e              pend_op,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] cmd,
    input  logic             eng_done,
    input  logic             eng_fail,
    input  logic             blk_prot,
    input  logic             vpp_ok,
    output cis_e             next,
    output ctl_t             ctl,
    output stev_t            ev
);

    logic launch;

    always_comb begin
        next   = state;
        ctl    = '0;
        ev     = '0;
        launch = 1'b0;

        case (state)
            ST_READ: begin
                if (wr_en) begin
                    ctl.rm_we = 1'b1;
                    ctl.rm    = RM_STATUS;
                    case (cmd)
                        C_RD_ARRAY:  ctl.rm = RM_ARRAY;
                        C_RD_STATUS: ctl.rm = RM_STATUS;
                        C_RD_SIGN:   ctl.rm = RM_SIGN;
                        C_RD_QUERY:  ctl.rm = RM_QUERY;
                        C_CLEAR: begin
                            ev.clear = 1'b1;
                            ctl.rm   = RM_ARRAY;
                        end
                        C_PROG, C_PROG_ALT: begin
                            next        = ST_PROG_DATA;
                            ctl.pend_we = 1'b1;
                            ctl.pend_op = OP_PROG;
                        end
                        C_BLK_ERASE: begin
                            next        = ST_ERASE_CONF;
                            ctl.pend_we = 1'b1;
                            ctl.pend_op = OP_BLK_ERASE;
                        end
                        C_BNK_ERASE: begin
                            next        = ST_ERASE_CONF;
                            ctl.pend_we = 1'b1;
                            ctl.pend_op = OP_BANK_ERASE;
                        end
                        C_SETUP_60: next = ST_SETUP60;
                        C_OTP_PROG: begin
                            next        = ST_OTP_DATA;
                            ctl.pend_we = 1'b1;
                            ctl.pend_op = OP_OTP_PROG;
                        end
                        default: ctl.rm = RM_ARRAY;
                    endcase
                end
            end

            ST_PROG_DATA, ST_OTP_DATA: begin
                if (wr_en) launch = 1'b1;
            end

            ST_ERASE_CONF: begin
                if (wr_en) begin
                    if (cmd == C_CONFIRM) begin
                        launch = 1'b1;
                    end else begin
                        ev.abort  = 1'b1;
                        next      = ST_READ;
                        ctl.rm_we = 1'b1;
                        ctl.rm    = RM_STATUS;
                    end
                end
            end

            ST_SETUP60: begin
                if (wr_en) begin
                    next      = ST_READ;
                    ctl.rm_we = 1'b1;
                    ctl.rm    = RM_STATUS;
                    ctl.start = 1'b1;
                    case (cmd)
                        C_PROTECT: ctl.start_op = OP_PROTECT;
                        C_CONFIRM: ctl.start_op = OP_UNPROTECT;
                        C_LOCK:    ctl.start_op = OP_LOCK;
                        C_CFG:     ctl.start_op = OP_CFG;
                        default: begin
                            ctl.start = 1'b0;
                            ctl.rm    = RM_ARRAY;
                        end
                    endcase
                end
            end

            ST_BUSY: begin
                if (eng_done) begin
                    ev.done = 1'b1;
                    ev.fail = eng_fail;
                    next    = ST_READ;
                end else if (wr_en) begin
                    if (cmd == C_RD_STATUS) begin
                        ctl.rm_we = 1'b1;
                        ctl.rm    = RM_STATUS;
                    end else if (cmd == C_SUSPEND) begin
                        ctl.susp = 1'b1;
                        ev.susp  = 1'b1;
                        next     = ST_SUSP;
                    end
                end
            end

            ST_SUSP: begin
                if (wr_en) begin
                    case (cmd)
                        C_CONFIRM: begin
                            ctl.resume = 1'b1;
                            ev.resume  = 1'b1;
                            next       = ST_BUSY;
                        end
                        C_RD_ARRAY: begin
                            ctl.rm_we = 1'b1;
                            ctl.rm    = RM_ARRAY;
                        end
                        C_RD_STATUS: begin
                            ctl.rm_we = 1'b1;
                            ctl.rm    = RM_STATUS;
                        end
                        C_RD_SIGN: begin
                            ctl.rm_we = 1'b1;
                            ctl.rm    = RM_SIGN;
                        end
                        C_RD_QUERY: begin
                            ctl.rm_we = 1'b1;
                            ctl.rm    = RM_QUERY;
                        end
                        C_CLEAR: begin
                            ev.clear  = 1'b1;
                            ctl.rm_we = 1'b1;
                            ctl.rm    = RM_ARRAY;
                        end
                        default: ;
                    endcase
                end
            end

            default: next = ST_READ;
        endcase

        // start of a long operation: supply first, then protection
        if (launch) begin
            next      = ST_READ;
            ctl.rm_we = 1'b1;
            ctl.rm    = RM_STATUS;
            if (!vpp_ok) begin
                ev.vlow = 1'b1;
            end else if (blk_prot) begin
                ev.prot = 1'b1;
            end else begin
                ctl.start    = 1'b1;
                ctl.start_op = pend_op;
                ev.busy      = 1'b1;
                next         = ST_BUSY;
            end
        end
    end

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stev_t             ev,
    input  op_e               run_op,
    output logic [STAT_W-1:0] status
);

    logic [STAT_W-1:0] st_q;
    logic              run_erase;

    assign run_erase = is_erase(run_op);
    assign status    = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= STAT_RESET;
        end else begin
            if (ev.clear) begin
                st_q[SB_PROT] <= 1'b0;
                st_q[SB_VLOW] <= 1'b0;
                st_q[SB_PERR] <= 1'b0;
                st_q[SB_EERR] <= 1'b0;
            end
            if (ev.prot)  st_q[SB_PROT] <= 1'b1;
            if (ev.vlow)  st_q[SB_VLOW] <= 1'b1;
            if (ev.abort) begin
                st_q[SB_PERR] <= 1'b1;
                st_q[SB_EERR] <= 1'b1;
            end
            if (ev.busy)  st_q[SB_READY] <= 1'b0;
            if (ev.done) begin
                st_q[SB_READY] <= 1'b1;
                if (ev.fail) begin
                    if (run_erase) st_q[SB_EERR] <= 1'b1;
                    else           st_q[SB_PERR] <= 1'b1;
                end
            end
            if (ev.susp) begin
                st_q[SB_READY] <= 1'b1;
                if (run_erase) st_q[SB_ESUSP] <= 1'b1;
                else           st_q[SB_PSUSP] <= 1'b1;
            end
            if (ev.resume) begin
                st_q[SB_READY] <= 1'b0;
                st_q[SB_ESUSP] <= 1'b0;
                st_q[SB_PSUSP] <= 1'b0;
            end
            st_q[0] <= 1'b0;
        end
    end

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              blk_prot,
    input  logic              vpp_ok,
    output logic              eng_start,
    output logic [3:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_wdata,
    output logic              eng_suspend,
    output logic              eng_resume,
    output logic [1:0]        rd_mode,
    output logic [7:0]        status
);

    cis_e              state_q, state_d;
    op_e               pend_q, op_q;
    rmode_e            rm_q;
    logic              start_q, susp_q, resume_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    ctl_t              ctl;
    stev_t             ev;

    fcmd_decode u_dec (
        .state    (state_q),
        .pend_op  (pend_q),
        .wr_en    (wr_en),
        .cmd      (wr_data[CMD_W-1:0]),
        .eng_done (eng_done),
        .eng_fail (eng_fail),
        .blk_prot (blk_prot),
        .vpp_ok   (vpp_ok),
        .next     (state_d),
        .ctl      (ctl),
        .ev       (ev)
    );

    fcmd_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .run_op (op_q),
        .status (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_READ;
            pend_q   <= OP_NONE;
            op_q     <= OP_NONE;
            rm_q     <= RM_ARRAY;
            start_q  <= 1'b0;
            susp_q   <= 1'b0;
            resume_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            state_q  <= state_d;
            start_q  <= ctl.start;
            susp_q   <= ctl.susp;
            resume_q <= ctl.resume;
            if (ctl.pend_we) pend_q <= ctl.pend_op;
            if (ctl.rm_we)   rm_q   <= ctl.rm;
            if (ctl.start) begin
                op_q   <= ctl.start_op;
                addr_q <= wr_addr;
                data_q <= wr_data;
            end
        end
    end

    assign eng_start   = start_q;
    assign eng_op      = op_q;
    assign eng_addr    = addr_q;
    assign eng_wdata   = data_q;
    assign eng_suspend = susp_q;
    assign eng_resume  = resume_q;
    assign rd_mode     = rm_q;

endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] cmd,
    input logic       eng_done,
    input logic       eng_start,
    input logic       eng_suspend,
    input logic       eng_resume,
    input logic [1:0] rd_mode,
    input logic [7:0] status
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (status == 8'h80 && rd_mode == 2'd0 && !eng_start));

    // R3: engine pulses never overlap
    a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_start, eng_suspend, eng_resume}));

    a_r7_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        !status[7] |=> !eng_start);

    a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
        (!status[7] && eng_done) |=> status[7]);

    a_r9_suspend_flags: assert property (@(posedge clk) disable iff (rst)
        eng_suspend |-> (status[7] && (status[6] ^ status[2])));

    a_r10_resume_flags: assert property (@(posedge clk) disable iff (rst)
        eng_resume |-> (!status[7] && !status[6] && !status[2]));

    a_r13_sticky_error: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !(wr_en && cmd == 8'h50)) |=> status[5]);

endmodule

bind fcmd_ctrl fcmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .cmd         (wr_data[7:0]),
    .eng_done    (eng_done),
    .eng_start   (eng_start),
    .eng_suspend (eng_suspend),
    .eng_resume  (eng_resume),
    .rd_mode     (rd_mode),
    .status      (status)
);

// File: tb/fcmd_ctrl_tb.sv
`timescale 1ns/1ps
module fcmd_ctrl_tb;

    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          eng_done = 1'b0;
    logic          eng_fail = 1'b0;
    logic          blk_prot = 1'b0;
    logic          vpp_ok = 1'b1;
    logic          eng_start, eng_suspend, eng_resume;
    logic [3:0]    eng_op;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata;
    logic [1:0]    rd_mode;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fcmd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_done(eng_done), .eng_fail(eng_fail),
        .blk_prot(blk_prot), .vpp_ok(vpp_ok), .eng_start(eng_start),
        .eng_op(eng_op), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume),
        .rd_mode(rd_mode), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write; returns just after the capturing edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr('0, {8'h00, c});
    endtask

    task automatic done(input logic f);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = f;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status, 8'h80);
        chk("R1 rd_mode", rd_mode, 0);
        chk("R1 pulses", {eng_start, eng_suspend, eng_resume}, 0);
    endtask

    task automatic t_read_modes;
        cmd(8'h90); chk("R2 sign", rd_mode, 2);
        cmd(8'h98); chk("R2 query", rd_mode, 3);
        cmd(8'h70); chk("R2 status", rd_mode, 1);
        cmd(8'hFF); chk("R2 array", rd_mode, 0);
    endtask

    task automatic t_invalid;
        cmd(8'h90);
        cmd(8'h00);
        chk("R14 rd_mode", rd_mode, 0);
        chk("R14 status", status, 8'h80);
        chk("R14 start", eng_start, 0);
    endtask

    task automatic t_program;
        cmd(8'h40);
        chk("R3 no early start", eng_start, 0);
        wr(22'h12345, 16'hA5C3);
        chk("R3 start", eng_start, 1);
        chk("R3 op", eng_op, 1);
        chk("R3 addr", eng_addr, 22'h12345);
        chk("R3 data", eng_wdata, 16'hA5C3);
        chk("R3 busy", status, 8'h00);
        chk("R3 rd_mode", rd_mode, 1);
        cmd(8'hFF); chk("R7 array ignored", rd_mode, 1);
        cmd(8'h20); chk("R7 setup ignored", eng_start, 0);
        cmd(8'hD0); chk("R7 confirm ignored", eng_start, 0);
        chk("R7 still busy", status, 8'h00);
        done(1'b1);
        chk("R8 program fail", status, 8'h90);
        cmd(8'h50);
        chk("R13 clear", status, 8'h80);
        chk("R13 rd_mode", rd_mode, 0);
    endtask

    task automatic t_erase_suspend;
        cmd(8'h80); cmd(8'hD0);
        chk("R4 bank start", eng_start, 1);
        chk("R4 bank op", eng_op, 3);
        cmd(8'hB0);
        chk("R9 suspend pulse", eng_suspend, 1);
        chk("R9 erase suspend", status, 8'hC0);
        cmd(8'hFF); chk("R10 read while suspended", rd_mode, 0);
        cmd(8'hD0);
        chk("R10 resume pulse", eng_resume, 1);
        chk("R10 resumed", status, 8'h00);
        done(1'b1);
        chk("R8 erase fail", status, 8'hA0);
        cmd(8'h50);
    endtask

    task automatic t_block_erase;
        cmd(8'h20); cmd(8'hD0);
        chk("R4 block op", {eng_start, eng_op}, {1'b1, 4'd2});
        done(1'b0);
        chk("R8 clean done", status, 8'h80);
    endtask

    task automatic t_prog_suspend;
        cmd(8'h10); wr(22'h5, 16'h1234);
        chk("R3 alt start", {eng_start, eng_op}, {1'b1, 4'd1});
        cmd(8'hB0); chk("R9 program suspend", status, 8'h84);
        cmd(8'hD0); chk("R10 program resume", status, 8'h00);
        done(1'b0); chk("R8 program ok", status, 8'h80);
    endtask

    task automatic t_erase_bad;
        cmd(8'h20); cmd(8'hFF);
        chk("R5 no start", eng_start, 0);
        chk("R5 status", status, 8'hB0);
        chk("R5 rd_mode", rd_mode, 1);
        cmd(8'h70); chk("R13 sticky", status, 8'hB0);
        cmd(8'h50); chk("R13 cleared", status, 8'h80);
    endtask

    task automatic t_setup60;
        cmd(8'h60); cmd(8'h01);
        chk("R6 protect", {eng_start, eng_op}, {1'b1, 4'd5});
        chk("R6 stays ready", status, 8'h80);
        cmd(8'h60); cmd(8'hD0);
        chk("R6 unprotect", {eng_start, eng_op}, {1'b1, 4'd6});
        cmd(8'h60); cmd(8'h2F);
        chk("R6 lock", {eng_start, eng_op}, {1'b1, 4'd7});
        cmd(8'h60); cmd(8'h03);
        chk("R6 config", {eng_start, eng_op}, {1'b1, 4'd8});
        chk("R6 config ready", status, 8'h80);
        cmd(8'h60); cmd(8'h55);
        chk("R6 bad second", {eng_start, rd_mode}, {1'b0, 2'd0});
        cmd(8'hC0); wr(22'h80, 16'hBEEF);
        chk("R6 otp start", {eng_start, eng_op}, {1'b1, 4'd4});
        chk("R6 otp data", eng_wdata, 16'hBEEF);
        done(1'b1);
        chk("R8 otp fail", status, 8'h90);
        cmd(8'h50);
    endtask

    task automatic t_protected;
        blk_prot = 1'b1;
        cmd(8'h20); cmd(8'hD0);
        chk("R11 no start", eng_start, 0);
        chk("R11 status", status, 8'h82);
        blk_prot = 1'b0;
        cmd(8'h50);
        chk("R13 prot cleared", status, 8'h80);
    endtask

    task automatic t_supply;
        vpp_ok = 1'b0; blk_prot = 1'b1;
        cmd(8'h40); wr(22'h7, 16'h0F0F);
        chk("R12 no start", eng_start, 0);
        chk("R12 status", status, 8'h88);
        vpp_ok = 1'b1; blk_prot = 1'b0;
        cmd(8'h50);
    endtask

    task automatic t_clear_suspended;
        cmd(8'h20); cmd(8'h00);
        cmd(8'h20); cmd(8'hD0);
        chk("R13 errors kept during op", status, 8'h30);
        cmd(8'hB0);
        chk("R9 suspend with errors", status, 8'hF0);
        cmd(8'h50);
        chk("R13 clear keeps suspend", status, 8'hC0);
        cmd(8'hD0);
        done(1'b0);
        chk("R8 finish", status, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_invalid();
        t_program();
        t_erase_suspend();
        t_block_erase();
        t_prog_suspend();
        t_erase_bad();
        t_setup60();
        t_protected();
        t_supply();
        t_clear_suspended();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule